// File: doc/BRIEF.md
# External Bus Access Sequencer

This block converts single-word read and write requests from inside the chip into timed strobe sequences on an external parallel memory bus. It drives a chip select, a read strobe, a write strobe, an address latch strobe, a full address bus and a shared address/data bus with an output enable. Each access walks through an optional address phase (pre-latch and latch), then setup, strobe and hold phases. The length of each phase is taken from its own input count.

On the internal side, a request is held until `ready_o` pulses. The address, the write data, the direction and every timing count are captured when the request is accepted. Read data appears on `rdata_o` when `ready_o` pulses. The polarity of each strobe line is chosen per line, and the bus mode decides whether the address is multiplexed onto the data bus and whether data is eight or sixteen bits wide.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is held, every strobe output sits at its inactive level for the selected polarity, `ad_oe_o` is 0 and `ready_o` is 0.
- R2: After acceptance, chip select is active for a contiguous run of exactly addr + setup + strobe + hold cycles. The first strobe cycle follows addr + setup cycles, where addr is 0 in non-multiplexed modes. The setup count may be 0.
- R3: A read asserts only the read strobe, for max(rd_strobe,1) cycles. A write asserts only the write strobe, for max(wr_strobe,1) cycles. Reads use the rd_* counts and writes use the wr_* counts.
- R4: Chip select stays active for exactly `hold` cycles after the last strobe cycle. The hold count may be 0.
- R5: Modes 1 (16-bit data, multiplexed) and 2 (8-bit data, multiplexed) insert max(alat_pre,1) cycles with the address on `ad_o` and the latch strobe inactive. These are followed by max(alat_post,1) cycles with the latch strobe active and the address still on `ad_o`. Modes 0 (8-bit, non-multiplexed) and 3 (treated like 0) never activate the latch strobe.
- R6: Read data is taken from `ad_i` at the clock edge that ends the last read strobe cycle. In 8-bit modes (0, 2, 3) only bits 7:0 are kept and the upper bits read 0.
- R7: During the setup, strobe and hold phases of a write, `ad_oe_o` is 1 and `ad_o` carries the write data (upper byte zero in 8-bit modes). During those phases of a read, `ad_oe_o` is 0.
- R8: `pol_i` bit 0 selects chip select, bit 1 the read strobe, bit 2 the write strobe and bit 3 the latch strobe. A 1 makes that line active-high and a 0 makes it active-low.
- R9: `ready_o` is high for exactly one cycle, in the first cycle after hold, with chip select already inactive. Requests are accepted only when idle and `ready_o` is low. Changes to the address, data, mode or timing inputs after acceptance have no effect on the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ready |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read data |
| mode_i | input | 2 | Bus mode: 0 8-bit plain, 1 16-bit muxed, 2 8-bit muxed, 3 as 0 |
| pol_i | input | 4 | Per-line polarity: {latch, write, read, select}, 1 = active high |
| rd_setup_i | input | 2 | Read setup cycles |
| rd_strobe_i | input | 4 | Read strobe cycles (0 acts as 1) |
| rd_hold_i | input | 2 | Read hold cycles |
| wr_setup_i | input | 2 | Write setup cycles |
| wr_strobe_i | input | 4 | Write strobe cycles (0 acts as 1) |
| wr_hold_i | input | 2 | Write hold cycles |
| alat_pre_i | input | 2 | Address cycles before latch strobe (0 acts as 1) |
| alat_post_i | input | 2 | Latch strobe cycles (0 acts as 1) |
| cs_o | output | 1 | Chip select pin |
| re_o | output | 1 | Read strobe pin |
| we_o | output | 1 | Write strobe pin |
| ale_o | output | 1 | Address latch strobe pin |
| addr_o | output | ADDR_W | Address bus, zero when idle |
| ad_o | output | DATA_W | Shared address/data bus output |
| ad_oe_o | output | 1 | Output enable for ad_o |
| ad_i | input | DATA_W | Shared bus input for reads |

## Verification
The bench targets the zero counts. A sequencer that treats a zero strobe literally would emit no strobe, and one that forces the minimum on setup or hold would stretch chip select by a cycle. It drives the read bus with one value only during read-strobe cycles and with its complement otherwise, so a capture one edge late returns the complement. It also scrambles the address, data and timing inputs right after acceptance: a design that reads them live would change its phase lengths or bus contents in the middle of an access. Non-multiplexed modes and all polarity combinations are covered, and these catch a latch strobe pulsed in the wrong mode or a line with inverted polarity.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  parameter int CNT_W = 2;
  parameter int STB_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_APRE, PH_ALAT, PH_SETUP, PH_STRB, PH_HOLD
  } ph_e;

  typedef struct packed {
    logic             mux;
    logic [CNT_W-1:0] apre;
    logic [CNT_W-1:0] alat;
    logic [CNT_W-1:0] setup;
    logic [STB_W-1:0] strb;
    logic [CNT_W-1:0] hold;
  } acc_cfg_t;

  function automatic logic [STB_W-1:0] at_least_one(logic [STB_W-1:0] v);
    return (v == '0) ? STB_W'(1) : v;
  endfunction

  function automatic logic [STB_W-1:0] ph_len(ph_e ph, acc_cfg_t c);
    case (ph)
      PH_APRE:  ph_len = c.mux ? at_least_one(STB_W'(c.apre)) : '0;
      PH_ALAT:  ph_len = c.mux ? at_least_one(STB_W'(c.alat)) : '0;
      PH_SETUP: ph_len = STB_W'(c.setup);
      PH_STRB:  ph_len = at_least_one(c.strb);
      PH_HOLD:  ph_len = STB_W'(c.hold);
      default:  ph_len = '0;
    endcase
  endfunction

  // first later phase with non-zero length, else idle
  function automatic ph_e ph_next(ph_e ph, acc_cfg_t c);
    ph_next = PH_IDLE;
    for (int k = int'(PH_HOLD); k > int'(ph); k--) begin
      if (ph_len(ph_e'(3'(k)), c) != '0) ph_next = ph_e'(3'(k));
    end
  endfunction
endpackage

// File: rtl/ebs_seq.sv
module ebs_seq
  import ebs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  acc_cfg_t cfg_i,
  output ph_e      phase_o,
  output logic     last_o,
  output logic     done_o
);
  ph_e              ph_q, nxt_ph;
  logic [STB_W-1:0] cnt_q, nxt_len;
  acc_cfg_t         cfg_q;
  logic             done_q;

  always_comb begin
    if (ph_q == PH_IDLE) begin
      nxt_ph  = ph_next(PH_IDLE, cfg_i);
      nxt_len = ph_len(nxt_ph, cfg_i);
    end else begin
      nxt_ph  = ph_next(ph_q, cfg_q);
      nxt_len = ph_len(nxt_ph, cfg_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ph_q == PH_IDLE) begin
        if (start_i) begin
          cfg_q <= cfg_i;
          ph_q  <= nxt_ph;
          cnt_q <= nxt_len - 1'b1;
        end
      end else if (cnt_q == '0) begin
        ph_q <= nxt_ph;
        if (nxt_ph == PH_IDLE) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= nxt_len - 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign phase_o = ph_q;
  assign last_o  = (ph_q != PH_IDLE) && (cnt_q == '0);
  assign done_o  = done_q;

  // R9
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R2
  setup_to_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SETUP && cnt_q == '0) |=> (ph_q == PH_STRB));
  // R4
  hold_ends_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_HOLD && cnt_q == '0) |=> (ph_q == PH_IDLE && done_q));
endmodule

// File: rtl/ebs_pins.sv
module ebs_pins
  import ebs_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ph_e               phase_i,
  input  logic              wr_i,
  input  logic              narrow_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [3:0]        pol_i,
  output logic              cs_o,
  output logic              re_o,
  output logic              we_o,
  output logic              ale_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o
);
  localparam int PAD_W = DATA_W - NARROW_W;

  logic cs_act, re_act, we_act, ale_act, addr_ph, data_ph;

  assign cs_act  = phase_i != PH_IDLE;
  assign re_act  = (phase_i == PH_STRB) && !wr_i;
  assign we_act  = (phase_i == PH_STRB) && wr_i;
  assign ale_act = phase_i == PH_ALAT;
  assign addr_ph = (phase_i == PH_APRE) || ale_act;
  assign data_ph = (phase_i == PH_SETUP) || (phase_i == PH_STRB) || (phase_i == PH_HOLD);

  always_comb begin
    ad_oe_o = 1'b0;
    ad_o    = '0;
    if (addr_ph) begin
      ad_oe_o = 1'b1;
      ad_o    = addr_i[DATA_W-1:0];
    end else if (data_ph && wr_i) begin
      ad_oe_o = 1'b1;
      ad_o    = narrow_i ? {{PAD_W{1'b0}}, wdata_i[NARROW_W-1:0]} : wdata_i;
    end
  end

  assign addr_o = cs_act ? addr_i : '0;

  // pin equals active level when polarity bit is 1, inverted when 0
  assign cs_o  = ~(cs_act  ^ pol_i[0]);
  assign re_o  = ~(re_act  ^ pol_i[1]);
  assign we_o  = ~(we_act  ^ pol_i[2]);
  assign ale_o = ~(ale_act ^ pol_i[3]);

  // R7
  read_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ph && !wr_i) |-> !ad_oe_o);
  // R5
  ale_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o == pol_i[3]) |-> (ad_oe_o && ad_o == addr_i[DATA_W-1:0]));
  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((re_o == pol_i[1]) && (we_o == pol_i[2])));
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [1:0]        mode_i,
  input  logic [3:0]        pol_i,
  input  logic [1:0]        rd_setup_i,
  input  logic [3:0]        rd_strobe_i,
  input  logic [1:0]        rd_hold_i,
  input  logic [1:0]        wr_setup_i,
  input  logic [3:0]        wr_strobe_i,
  input  logic [1:0]        wr_hold_i,
  input  logic [1:0]        alat_pre_i,
  input  logic [1:0]        alat_post_i,
  output logic              cs_o,
  output logic              re_o,
  output logic              we_o,
  output logic              ale_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i
);
  localparam int PAD_W = DATA_W - NARROW_W;

  ph_e               phase;
  logic              last, done, accept, mux_n, narrow_n;
  acc_cfg_t          cfg_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              wr_q, narrow_q;

  assign mux_n    = (mode_i == 2'd1) || (mode_i == 2'd2);
  assign narrow_n = mode_i != 2'd1;
  assign accept   = req_i && !done && (phase == PH_IDLE);

  always_comb begin
    cfg_n.mux   = mux_n;
    cfg_n.apre  = alat_pre_i;
    cfg_n.alat  = alat_post_i;
    cfg_n.setup = we_i ? wr_setup_i  : rd_setup_i;
    cfg_n.strb  = we_i ? wr_strobe_i : rd_strobe_i;
    cfg_n.hold  = we_i ? wr_hold_i   : rd_hold_i;
  end

  ebs_seq u_seq (
    .clk_i, .rst_ni,
    .start_i (accept),
    .cfg_i   (cfg_n),
    .phase_o (phase),
    .last_o  (last),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      wr_q     <= 1'b0;
      narrow_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (accept) begin
        addr_q   <= addr_i;
        wdata_q  <= wdata_i;
        wr_q     <= we_i;
        narrow_q <= narrow_n;
      end
      if (phase == PH_STRB && last && !wr_q)
        rdata_q <= narrow_q ? {{PAD_W{1'b0}}, ad_i[NARROW_W-1:0]} : ad_i;
    end
  end

  ebs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_pins (
    .clk_i, .rst_ni,
    .phase_i  (phase),
    .wr_i     (wr_q),
    .narrow_i (narrow_q),
    .addr_i   (addr_q),
    .wdata_i  (wdata_q),
    .pol_i,
    .cs_o, .re_o, .we_o, .ale_o, .addr_o, .ad_o, .ad_oe_o
  );

  assign ready_o = done;
  assign rdata_o = rdata_q;

  // R9
  cs_off_at_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cs_o != pol_i[0]));
  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o == pol_i[0]) && $past(cs_o == pol_i[0]) |-> $stable(addr_o));
endmodule

// File: tb/ext_bus_seq_test.sv
`timescale 1ns/1ps
module ext_bus_seq_test;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [23:0] addr = 0;
  logic [15:0] wdata = 0, ad_in = 0;
  logic        ready, cs, re, wen, ale, ad_oe;
  logic [15:0] rdata, ad_out;
  logic [23:0] addr_out;
  logic [1:0]  mode = 0;
  logic [3:0]  pol = 4'b0101;
  logic [1:0]  rs = 0, rh = 0, ws = 0, wh = 0, ap = 0, al = 0;
  logic [3:0]  rb = 0, wb = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ext_bus_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .mode_i(mode),
    .pol_i(pol), .rd_setup_i(rs), .rd_strobe_i(rb), .rd_hold_i(rh),
    .wr_setup_i(ws), .wr_strobe_i(wb), .wr_hold_i(wh), .alat_pre_i(ap),
    .alat_post_i(al), .cs_o(cs), .re_o(re), .we_o(wen), .ale_o(ale),
    .addr_o(addr_out), .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mx1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit act(input logic pin, input logic p);
    return ~(pin ^ p);
  endfunction

  task automatic access(input bit wr, input logic [23:0] a, input logic [15:0] d);
    bit mux = (mode == 2'd1) || (mode == 2'd2);
    bit nar = (mode != 2'd1);
    int st  = wr ? int'(ws) : int'(rs);
    int sb  = mx1(wr ? int'(wb) : int'(rb));
    int hd  = wr ? int'(wh) : int'(rh);
    int pre = mux ? mx1(int'(ap)) + mx1(int'(al)) : 0;
    int tot = pre + st + sb + hd;
    logic [15:0] rv = 16'($urandom);
    logic [15:0] dm = nar ? {8'h00, d[7:0]} : d;
    logic [1:0] s_rs = rs, s_rh = rh, s_ws = ws, s_wh = wh, s_ap = ap, s_al = al, s_mode = mode;
    logic [3:0] s_rb = rb, s_wb = wb;
    int n = 0, cs_cnt = 0, ale_cnt = 0, first_ale = -1, first_s = -1, last_s = -1;
    bit bad_bus = 0, bad_kind = 0, bad_addr = 0, got = 0, cs_at_ready = 0;
    addr = a; wdata = d; we = wr; req = 1; ad_in = ~rv;
    while (!got && n < 200) begin
      @(negedge clk);
      if (n == 0) begin
        addr = 24'($urandom); wdata = 16'($urandom); mode = 2'($urandom);
        rs = 2'($urandom); rb = 4'($urandom); rh = 2'($urandom);
        ws = 2'($urandom); wb = 4'($urandom); wh = 2'($urandom);
        ap = 2'($urandom); al = 2'($urandom);
      end
      if (ready) begin
        got = 1;
        cs_at_ready = act(cs, pol[0]);
        req = 0;
      end else begin
        if (act(cs, pol[0])) cs_cnt++;
        if (act(ale, pol[3])) begin
          ale_cnt++;
          if (first_ale < 0) first_ale = cs_cnt - 1;
        end
        if (act(re, pol[1]) || act(wen, pol[2])) begin
          if (first_s < 0) first_s = cs_cnt - 1;
          last_s = cs_cnt - 1;
          if (act(re, pol[1]) == wr || act(wen, pol[2]) != wr) bad_kind = 1;
        end
        if (addr_out != a) bad_addr = 1;
        if (cs_cnt - 1 < pre) begin
          if (!ad_oe || ad_out != a[15:0]) bad_bus = 1;
        end else if (wr) begin
          if (!ad_oe || ad_out != dm) bad_bus = 1;
        end else if (ad_oe) bad_bus = 1;
        ad_in = act(re, pol[1]) ? rv : ~rv;
      end
      n++;
    end
    chk(got, "R9 ready seen", int'(got), 1);
    chk(!cs_at_ready, "R9 cs inactive at ready", int'(cs_at_ready), 0);
    chk(cs_cnt == tot, "R2 cs active cycles", cs_cnt, tot);
    chk(first_s == pre + st, "R2 first strobe cycle", first_s, pre + st);
    chk(last_s - first_s + 1 == sb, "R3 strobe length", last_s - first_s + 1, sb);
    chk(!bad_kind, "R3 strobe line choice", int'(bad_kind), 0);
    chk(cs_cnt - 1 - last_s == hd, "R4 hold length", cs_cnt - 1 - last_s, hd);
    chk(ale_cnt == (mux ? mx1(int'(s_al)) : 0), "R5 latch strobe cycles", ale_cnt,
        mux ? mx1(int'(s_al)) : 0);
    if (mux) chk(first_ale == mx1(int'(s_ap)), "R5 pre-latch cycles", first_ale, mx1(int'(s_ap)));
    chk(!bad_bus, "R7 shared bus contents", int'(bad_bus), 0);
    chk(!bad_addr, "R9 address held from acceptance", int'(bad_addr), 0);
    if (!wr) chk(rdata == (nar ? {8'h00, rv[7:0]} : rv), "R6 read data", int'(rdata),
                 int'(nar ? {8'h00, rv[7:0]} : rv));
    @(negedge clk);
    chk(!ready && !act(cs, pol[0]), "R9 single ready pulse, idle after", int'(ready), 0);
    rs = s_rs; rb = s_rb; rh = s_rh; ws = s_ws; wb = s_wb; wh = s_wh;
    ap = s_ap; al = s_al; mode = s_mode;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs == ~pol[0] && re == ~pol[1] && wen == ~pol[2] && ale == ~pol[3],
        "R1 inactive strobes in reset", int'({cs, re, wen, ale}), int'(~pol));
    chk(!ad_oe && !ready, "R1 bus released, no ready", int'({ad_oe, ready}), 0);
    rst_n = 1;
    @(negedge clk);
    // zero counts, every mode, both directions
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m); rs = 0; rb = 0; rh = 0; ws = 0; wb = 0; wh = 0; ap = 0; al = 0;
      access(0, 24'h12A5C3, 16'hBEEF);
      access(1, 24'h00F00D, 16'hCAFE);
    end
    // maximum counts
    mode = 1; rs = 3; rb = 15; rh = 3; ws = 3; wb = 15; wh = 3; ap = 3; al = 3;
    access(0, 24'hFFFFFF, 16'h0000);
    access(1, 24'h800001, 16'hFFFF);
    // R8 each polarity pattern
    for (int p = 0; p < 16; p++) begin
      pol = 4'(p); mode = 2;
      rs = 1; rb = 2; rh = 1; ws = 2; wb = 1; wh = 2; ap = 1; al = 2;
      access(p[0], 24'(p * 24'h010203), 16'(p * 16'h1111));
    end
    // random mix
    for (int i = 0; i < 60; i++) begin
      pol = 4'($urandom); mode = 2'($urandom);
      rs = 2'($urandom); rb = 4'($urandom); rh = 2'($urandom);
      ws = 2'($urandom); wb = 4'($urandom); wh = 2'($urandom);
      ap = 2'($urandom); al = 2'($urandom);
      access(1'($urandom), 24'($urandom), 16'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule